// File: doc/BRIEF.md
# Program-Flow Discontinuity Recorder

This block keeps a short history of the places where a processor's program counter stopped advancing in straight-line order. Each cycle a producer may present a program counter together with a valid strobe. The block compares that value against the last valid value it saw. If the new value is anything other than the old value plus one instruction step (four bytes), it is stored in a ring of entries and the write position moves on. Straight-line fetches leave no trace, so the ring fills only with branch, jump and exception targets.

A debug host reads the ring through a combinational port addressed relative to the write position. Offset zero gives the oldest surviving entry and the highest offset gives the newest. Slots that have never been written since the last reset or clear read back as all ones. A synchronous reset and a separate clear input both empty the ring. The current write position is also driven out, so that wrap-around can be observed.

Top module: `pc_jump_trace`

## Requirements
- R1: After a synchronous reset every slot reads 32'hFFFFFFFF, `head_o` is 0 and the remembered previous program counter is 0.
- R2: A valid sample whose value differs from the remembered value plus 4 (modulo 2^32) is written into the slot at `head_o`. It is readable from the next cycle on at offset DEPTH-1, the newest position.
- R3: A valid sample equal to the remembered value plus 4 writes nothing and leaves `head_o` unchanged. This includes the case 32'hFFFFFFFC followed by 32'h00000000.
- R4: Every write advances `head_o` by one and wraps from DEPTH-1 (31) to 0. Once the ring is full, each new write replaces the oldest entry.
- R5: Every valid sample replaces the remembered previous value, whether or not it was written into the ring.
- R6: A cycle with `pc_valid_i` low changes neither the ring, nor `head_o`, nor the remembered value, whatever `pc_i` carries.
- R7: `rd_data_o` shows slot (`head_o` + `rd_ofs_i`) mod DEPTH in the same cycle, with no register in the path. Offset 0 is the oldest slot and offset DEPTH-1 is the newest.
- R8: When `clr_i` is high, the next state equals the reset state of R1. A valid sample in the same cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| clr_i | input | 1 | Synchronous clear of ring, write position and remembered value |
| pc_valid_i | input | 1 | `pc_i` carries a sample this cycle |
| pc_i | input | 32 | Program counter sample |
| rd_ofs_i | input | 5 | Read offset counted from the write position |
| rd_data_o | output | 32 | Slot selected by `rd_ofs_i` |
| head_o | output | 5 | Current write position |

## Verification
A sample, clear or reset presented before a rising edge shows up in `head_o` and in the slot contents one cycle later, right after that edge. `rd_data_o` follows `rd_ofs_i` with no cycle of delay. The bench therefore applies each stimulus away from the edge and advances its behavioural model at the edge. A quarter of a period later it compares `head_o`, then steps `rd_ofs_i` through every offset, allowing one time unit each, and compares every slot before the next edge arrives.

// File: rtl/jt_pkg.sv
package jt_pkg;

    // What a single cycle does to the recorder state
    typedef enum logic [1:0] {
        JT_HOLD    = 2'd0,   // no valid sample
        JT_SEQ     = 2'd1,   // sequential sample: remember only
        JT_CAPTURE = 2'd2,   // discontinuity: store and remember
        JT_CLEAR   = 2'd3    // empty everything
    } jt_act_e;

    localparam int JT_DEF_WIDTH = 32;
    localparam int JT_DEF_DEPTH = 32;
    localparam int JT_DEF_STEP  = 4;

endpackage

// File: rtl/jt_break_detect.sv
module jt_break_detect
    import jt_pkg::*;
#(
    parameter int W    = JT_DEF_WIDTH,
    parameter int STEP = JT_DEF_STEP
) (
    input  logic         clr,
    input  logic         valid,
    input  logic [W-1:0] pc,
    input  logic [W-1:0] last_pc,
    output jt_act_e      act
);
    localparam logic [W-1:0] STEP_V = W'(STEP);

    logic [W-1:0] expect_pc;

    always_comb begin
        expect_pc = last_pc + STEP_V;
        if (clr) begin
            act = JT_CLEAR;
        end else if (!valid) begin
            act = JT_HOLD;
        end else if (pc == expect_pc) begin
            act = JT_SEQ;
        end else begin
            act = JT_CAPTURE;
        end
    end

endmodule

// File: rtl/jt_ring.sv
module jt_ring
    import jt_pkg::*;
#(
    parameter int W     = JT_DEF_WIDTH,
    parameter int DEPTH = JT_DEF_DEPTH,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  jt_act_e                   act,
    input  logic [W-1:0]              wr_data,
    output logic [IDX_W-1:0]          head,
    output logic [DEPTH-1:0][W-1:0]   slots
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    typedef struct packed {
        logic [IDX_W-1:0]        head;
        logic [DEPTH-1:0][W-1:0] slots;
    } ring_t;

    ring_t ring_d, ring_q;

    always_comb begin
        ring_d = ring_q;
        unique case (act)
            JT_CLEAR: begin
                ring_d.head = '0;
                for (int s = 0; s < DEPTH; s++) begin
                    ring_d.slots[s] = '1;
                end
            end
            JT_CAPTURE: begin
                for (int s = 0; s < DEPTH; s++) begin
                    if (ring_q.head == IDX_W'(s)) begin
                        ring_d.slots[s] = wr_data;
                    end
                end
                ring_d.head = (ring_q.head == LAST_IDX) ? '0 : ring_q.head + 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ring_q.head  <= '0;
            ring_q.slots <= '1;
        end else begin
            ring_q <= ring_d;
        end
    end

    assign head  = ring_q.head;
    assign slots = ring_q.slots;

endmodule

// File: rtl/jt_tap.sv
module jt_tap
    import jt_pkg::*;
#(
    parameter int W     = JT_DEF_WIDTH,
    parameter int DEPTH = JT_DEF_DEPTH,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0][W-1:0] slots,
    input  logic [IDX_W-1:0]        head,
    input  logic [IDX_W-1:0]        ofs,
    output logic [W-1:0]            data
);
    localparam bit POW2 = ((1 << IDX_W) == DEPTH);

    logic [IDX_W-1:0] idx;

    generate
        if (POW2) begin : g_pow2
            // natural wrap of the index width
            assign idx = head + ofs;
        end else begin : g_mod
            logic [IDX_W:0] sum;
            assign sum = {1'b0, head} + {1'b0, ofs};
            assign idx = (sum >= (IDX_W+1)'(DEPTH)) ? IDX_W'(sum - (IDX_W+1)'(DEPTH))
                                                     : sum[IDX_W-1:0];
        end
    endgenerate

    assign data = slots[idx];

endmodule

// File: rtl/pc_jump_trace.sv
module pc_jump_trace
    import jt_pkg::*;
#(
    parameter int W     = JT_DEF_WIDTH,
    parameter int DEPTH = JT_DEF_DEPTH,
    parameter int STEP  = JT_DEF_STEP,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             pc_valid_i,
    input  logic [W-1:0]     pc_i,
    input  logic [IDX_W-1:0] rd_ofs_i,
    output logic [W-1:0]     rd_data_o,
    output logic [IDX_W-1:0] head_o
);
    typedef struct packed {
        logic [W-1:0] last;
    } track_t;

    track_t  track_d, track_q;
    jt_act_e act;
    logic [DEPTH-1:0][W-1:0] slots;
    logic [W-1:0] last_pc;

    assign last_pc = track_q.last;

    jt_break_detect #(.W(W), .STEP(STEP)) u_detect (
        .clr     (clr_i),
        .valid   (pc_valid_i),
        .pc      (pc_i),
        .last_pc (last_pc),
        .act     (act)
    );

    jt_ring #(.W(W), .DEPTH(DEPTH)) u_ring (
        .clk     (clk),
        .rst     (rst),
        .act     (act),
        .wr_data (pc_i),
        .head    (head_o),
        .slots   (slots)
    );

    jt_tap #(.W(W), .DEPTH(DEPTH)) u_tap (
        .slots (slots),
        .head  (head_o),
        .ofs   (rd_ofs_i),
        .data  (rd_data_o)
    );

    always_comb begin
        track_d = track_q;
        unique case (act)
            JT_CLEAR:            track_d.last = '0;
            JT_SEQ, JT_CAPTURE:  track_d.last = pc_i;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            track_q.last <= '0;
        end else begin
            track_q <= track_d;
        end
    end

endmodule

// File: rtl/jt_check.sv
module jt_check #(
    parameter int W     = 32,
    parameter int STEP  = 4,
    parameter int IDX_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             clr_i,
    input logic             pc_valid_i,
    input logic [W-1:0]     pc_i,
    input logic [IDX_W-1:0] head_o,
    input logic [W-1:0]     last_pc
);
    localparam logic [W-1:0] STEP_V = W'(STEP);

    AST_BREAK_ADVANCES: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && pc_valid_i && pc_i != last_pc + STEP_V) |=> head_o == $past(head_o) + 1'b1); // R4

    AST_SEQ_KEEPS_HEAD: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && pc_valid_i && pc_i == last_pc + STEP_V) |=> $stable(head_o)); // R3

    AST_IDLE_KEEPS_ALL: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && !pc_valid_i) |=> ($stable(head_o) && $stable(last_pc))); // R6

    AST_SAMPLE_REMEMBERED: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && pc_valid_i) |=> last_pc == $past(pc_i)); // R5

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (head_o == '0 && last_pc == '0)); // R8

endmodule

bind pc_jump_trace jt_check #(.W(W), .STEP(STEP), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .clr_i      (clr_i),
    .pc_valid_i (pc_valid_i),
    .pc_i       (pc_i),
    .head_o     (head_o),
    .last_pc    (last_pc)
);

// File: tb/sim_pc_jump_trace.sv
module sim_pc_jump_trace;
    localparam int CLK_P = 100;
    localparam int N     = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clr_i = 1'b0;
    logic        pc_valid_i = 1'b0;
    logic [31:0] pc_i = '0;
    logic [4:0]  rd_ofs_i = '0;
    logic [31:0] rd_data_o;
    logic [4:0]  head_o;

    int n_cmp = 0;
    int n_bad = 0;

    // behavioural reference
    logic [31:0] m_mem [N];
    int          m_head;
    logic [31:0] m_last;

    pc_jump_trace u0 (
        .clk(clk), .rst(rst), .clr_i(clr_i), .pc_valid_i(pc_valid_i),
        .pc_i(pc_i), .rd_ofs_i(rd_ofs_i), .rd_data_o(rd_data_o), .head_o(head_o)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_empty();
        for (int i = 0; i < N; i++) m_mem[i] = 32'hFFFF_FFFF;
        m_head = 0;
        m_last = 32'h0;
    endtask

    task automatic model_step(bit r, bit v, logic [31:0] pc, bit c);
        if (r || c) begin
            model_empty();
        end else if (v) begin
            if (pc != m_last + 32'd4) begin
                m_mem[m_head] = pc;
                m_head = (m_head + 1) % N;
            end
            m_last = pc;
        end
    endtask

    // head check plus full sweep of every read offset (R7 path)
    task automatic compare(string tag);
        check({tag, " head"}, {27'd0, head_o}, m_head);
        for (int k = 0; k < N; k++) begin
            rd_ofs_i = 5'(k);
            #1;
            check({tag, " R7 slot"}, rd_data_o, m_mem[(m_head + k) % N]);
        end
    endtask

    task automatic cyc(bit v, logic [31:0] pc, bit c, string tag);
        pc_valid_i = v;
        pc_i       = pc;
        clr_i      = c;
        @(posedge clk);
        model_step(rst, v, pc, c);
        #(CLK_P/4);
        compare(tag);
    endtask

    initial begin
        #(CLK_P * 200000);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        model_empty();
        repeat (3) @(posedge clk);
        #(CLK_P/4);
        compare("R1 reset");
        rst = 1'b0;

        // invalid samples are ignored
        cyc(1'b0, 32'h0000_0500, 1'b0, "R6 idle");
        // from reset, last=0 so 4 is sequential
        cyc(1'b1, 32'h0000_0004, 1'b0, "R3 seq from reset");
        cyc(1'b1, 32'h0000_0008, 1'b0, "R3 seq");
        cyc(1'b1, 32'h0000_0100, 1'b0, "R2 jump");
        cyc(1'b1, 32'h0000_0104, 1'b0, "R5 seq after jump");
        cyc(1'b0, 32'h0000_0900, 1'b0, "R6 invalid jump value");
        cyc(1'b1, 32'h0000_0108, 1'b0, "R5 last kept over invalid");
        cyc(1'b1, 32'h0000_0108, 1'b0, "R2 repeat same pc");
        cyc(1'b1, 32'h0000_0104, 1'b0, "R2 backward");
        cyc(1'b1, 32'hFFFF_FFFC, 1'b0, "R2 top of range");
        cyc(1'b1, 32'h0000_0000, 1'b0, "R3 modular sequential");

        // fill past capacity to wrap and overwrite oldest
        for (int i = 0; i < 40; i++) begin
            cyc(1'b1, 32'h1000_0000 + 32'(i * 64), 1'b0, "R4 wrap fill");
        end
        cyc(1'b1, 32'h1000_0000 + 32'(39 * 64) + 32'd4, 1'b0, "R3 seq after wrap");

        // clear beats a simultaneous capture
        cyc(1'b1, 32'h2222_0000, 1'b1, "R8 clear with capture");
        cyc(1'b1, 32'h0000_0004, 1'b0, "R8 last zero after clear");
        cyc(1'b1, 32'h0000_3000, 1'b0, "R2 after clear");

        // mixed pattern
        for (int i = 0; i < 20; i++) begin
            cyc(1'b1, (i % 3 == 0) ? 32'h0000_7000 + 32'(i * 8) : m_last + 32'd4,
                1'b0, "R4 mixed");
            cyc(1'b0, 32'hDEAD_BEEF, 1'b0, "R6 mixed idle");
        end

        // reset in the middle of a run
        rst = 1'b1;
        cyc(1'b1, 32'h5555_0000, 1'b0, "R1 reset mid run");
        rst = 1'b0;
        cyc(1'b1, 32'h0000_0004, 1'b0, "R1 last zero after reset");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule